// File: doc/BRIEF.md
# Reset and Clock-Source Sequencer

This block merges three reset requests into a single internal core reset and decides which clock the core runs from afterwards. The three requests are loss of supply (power-on), a watchdog timeout pulse and an active-low external reset pin. Each source has its own hold-off count. Every exit from reset pulses a program-counter load strobe and presents the fixed reset vector.

The block is clocked by the ring-oscillator clock, which runs throughout every reset. It keeps the high-frequency-select bit, which only a power-on clears. After any reset the core runs from the ring oscillator. When the select bit is set, a warmup counter in the high-frequency clock domain must finish before the clock select moves over. That counter's done flag returns to the ring domain through a synchronizer.

Top module: `rst_clk_sequencer`

## Requirements
- R1: While `supply_ok` is low, `core_rst` is 1. `core_rst` falls on the ring edge POR_CYCLES edges after the edge that first samples `supply_ok` high.
- R2: The external pin passes through a two-flop synchronizer. A low pin sampled on edge t sets `core_rst` by edge t+2. After the pin rises, `core_rst` falls on the seventh ring edge from the first edge that samples it high: two synchronizer edges, one sampling edge, then EXT_DELAY=4 edges.
- R3: On the edge where `core_rst` falls, `pc_load` is 1 for exactly one cycle and `pc_vec` equals RESET_VECTOR (16'h8000).
- R4: `rst_cause` holds the source of the latest reset: 2'b00 power-on, 2'b01 watchdog, 2'b10 external. Power-on outranks both other sources. A synchronized low pin outranks a watchdog pulse.
- R5: `hf_sel_q` is cleared only while `supply_ok` is low. It is written from `hf_sel_wdata` when `hf_sel_we` is 1 and `core_rst` is 0. A write while `core_rst` is 1 is ignored. Watchdog and external resets leave the bit unchanged.
- R6: `clk_sel` (1 means high-frequency clock) is 0 whenever `core_rst` or `hf_sel_q` is 0. After an exit with the bit set, `clk_sel` rises no sooner than WARM_CYCLES high-frequency cycles later, and within a further 30.
- R7: A watchdog pulse sampled on edge W0 sets `core_rst` on W0. `core_rst` falls on W0+WDT_HOLD (4).
- R8: A watchdog or external request during a delay count or during warmup restarts that source's count and the warmup from the beginning. During the power-on count, watchdog and pin requests are ignored.
- R9: Clearing `hf_sel_q` while running drops `clk_sel` to 0 on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ring | input | 1 | Ring-oscillator clock, always running |
| clk_hf | input | 1 | High-frequency oscillator clock |
| supply_ok | input | 1 | Core supply in range; low forces power-on reset |
| rst_pin_n | input | 1 | Raw active-low external reset pin |
| wdt_timeout | input | 1 | One-cycle watchdog timeout pulse |
| hf_sel_we | input | 1 | Write strobe for the high-frequency select bit |
| hf_sel_wdata | input | 1 | Value written to the select bit |
| core_rst | output | 1 | Internal core reset, active high |
| rst_cause | output | 2 | Source of the latest reset |
| pc_load | output | 1 | One-cycle strobe at reset exit |
| pc_vec | output | 16 | Program-counter reset vector |
| hf_sel_q | output | 1 | Current high-frequency select bit |
| clk_sel | output | 1 | Clock select: 0 ring, 1 high-frequency |

## Verification
Two functions can meet in the same cycle: a watchdog pulse and a falling external pin. Because of the synchronizer, the watchdog is seen first and the pin two edges later. The bench drives both on one edge. It then checks that the cause ends as external and that release follows the pin timing. A second case lands a watchdog pulse inside a running warmup. There the bench counts high-frequency edges from the second exit, which shows that the warmup started over instead of finishing early.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [2:0] {
    ST_POR_WAIT,
    ST_POR_CNT,
    ST_EXT_HOLD,
    ST_EXT_CNT,
    ST_WDT_CNT,
    ST_RUN
  } seq_state_e;

  typedef enum logic [1:0] {
    CAUSE_POR = 2'b00,
    CAUSE_WDT = 2'b01,
    CAUSE_EXT = 2'b10
  } cause_e;
endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain <= d;
    end else begin : g_many
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rcs_reset_fsm.sv
module rcs_reset_fsm
  import rcs_pkg::*;
#(
  parameter int          POR_CYCLES   = 65536,
  parameter int          EXT_DELAY    = 4,
  parameter int          WDT_HOLD     = 4,
  parameter int          VEC_W        = 16,
  parameter logic [VEC_W-1:0] RESET_VECTOR = 16'h8000
) (
  input  logic             clk,
  input  logic             supply_ok,
  input  logic             pin_sync,
  input  logic             wdt_timeout,
  output logic             core_rst,
  output logic             rst_next,
  output logic [1:0]       rst_cause,
  output logic             pc_load,
  output logic [VEC_W-1:0] pc_vec
);
  localparam int MAX_A   = (POR_CYCLES > EXT_DELAY) ? POR_CYCLES : EXT_DELAY;
  localparam int MAX_CNT = (MAX_A > WDT_HOLD) ? MAX_A : WDT_HOLD;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_CYCLES - 1);
  localparam logic [CNT_W-1:0] EXT_LAST = CNT_W'(EXT_DELAY - 1);
  localparam logic [CNT_W-1:0] WDT_LAST = CNT_W'(WDT_HOLD - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  cause_e           cause_q, cause_d;
  logic             leaving;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cause_d = cause_q;
    if (!supply_ok) begin
      state_d = ST_POR_WAIT;
      cnt_d   = '0;
      cause_d = CAUSE_POR;
    end else begin
      case (state_q)
        ST_POR_WAIT: begin
          state_d = ST_POR_CNT;
          cnt_d   = '0;
        end
        ST_POR_CNT: begin
          if (cnt_q == POR_LAST) state_d = ST_RUN;
          else cnt_d = cnt_q + 1'b1;
        end
        default: begin
          if (!pin_sync) begin
            state_d = ST_EXT_HOLD;
            cnt_d   = '0;
            cause_d = CAUSE_EXT;
          end else if (wdt_timeout) begin
            state_d = ST_WDT_CNT;
            cnt_d   = '0;
            cause_d = CAUSE_WDT;
          end else if (state_q == ST_EXT_HOLD) begin
            state_d = ST_EXT_CNT;
            cnt_d   = '0;
          end else if (state_q == ST_EXT_CNT) begin
            if (cnt_q == EXT_LAST) state_d = ST_RUN;
            else cnt_d = cnt_q + 1'b1;
          end else if (state_q == ST_WDT_CNT) begin
            if (cnt_q == WDT_LAST) state_d = ST_RUN;
            else cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign rst_next = (state_d != ST_RUN);
  assign leaving  = core_rst && !rst_next;

  always_ff @(posedge clk) begin
    state_q  <= state_d;
    cnt_q    <= cnt_d;
    cause_q  <= cause_d;
    core_rst <= rst_next;
    pc_load  <= supply_ok && leaving;
    if (!supply_ok) pc_vec <= '0;
    else if (leaving) pc_vec <= RESET_VECTOR;
  end

  assign rst_cause = cause_q;
endmodule

// File: rtl/rcs_warmup.sv
module rcs_warmup #(
  parameter int WARM_CYCLES = 65536,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_hf,
  input  logic warm_req,
  output logic warm_done
);
  localparam int CW = $clog2(WARM_CYCLES + 1);
  localparam logic [CW-1:0] WARM_LAST = CW'(WARM_CYCLES - 1);

  logic          req_s;
  logic [CW-1:0] cnt_q;

  rcs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_hf), .d(warm_req), .q(req_s)
  );

  always_ff @(posedge clk_hf) begin
    if (!req_s) begin
      cnt_q     <= '0;
      warm_done <= 1'b0;
    end else if (cnt_q == WARM_LAST) begin
      warm_done <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rcs_clk_select.sv
module rcs_clk_select (
  input  logic clk,
  input  logic supply_ok,
  input  logic core_rst,
  input  logic rst_next,
  input  logic sel_we,
  input  logic sel_wdata,
  input  logic done_sync,
  output logic hf_sel_q,
  output logic warm_req,
  output logic clk_sel
);
  logic sel_next;
  logic armed;

  always_comb begin
    sel_next = hf_sel_q;
    if (!supply_ok) sel_next = 1'b0;
    else if (sel_we && !core_rst) sel_next = sel_wdata;
  end

  always_ff @(posedge clk) begin
    hf_sel_q <= sel_next;
    warm_req <= sel_next && !rst_next && supply_ok;
    armed    <= warm_req && (armed || !done_sync);
    clk_sel  <= sel_next && !rst_next && supply_ok && warm_req && armed && done_sync;
  end
endmodule

// File: rtl/rst_clk_sequencer.sv
module rst_clk_sequencer #(
  parameter int               POR_CYCLES   = 65536,
  parameter int               EXT_DELAY    = 4,
  parameter int               WDT_HOLD     = 4,
  parameter int               WARM_CYCLES  = 65536,
  parameter int               SYNC_STAGES  = 2,
  parameter int               VEC_W        = 16,
  parameter logic [VEC_W-1:0] RESET_VECTOR = 16'h8000
) (
  input  logic             clk_ring,
  input  logic             clk_hf,
  input  logic             supply_ok,
  input  logic             rst_pin_n,
  input  logic             wdt_timeout,
  input  logic             hf_sel_we,
  input  logic             hf_sel_wdata,
  output logic             core_rst,
  output logic [1:0]       rst_cause,
  output logic             pc_load,
  output logic [VEC_W-1:0] pc_vec,
  output logic             hf_sel_q,
  output logic             clk_sel
);
  logic pin_sync;
  logic rst_next;
  logic warm_req;
  logic warm_done;
  logic done_sync;

  rcs_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk_ring), .d(rst_pin_n), .q(pin_sync)
  );

  rcs_reset_fsm #(
    .POR_CYCLES(POR_CYCLES), .EXT_DELAY(EXT_DELAY), .WDT_HOLD(WDT_HOLD),
    .VEC_W(VEC_W), .RESET_VECTOR(RESET_VECTOR)
  ) u_fsm (
    .clk(clk_ring), .supply_ok(supply_ok), .pin_sync(pin_sync),
    .wdt_timeout(wdt_timeout), .core_rst(core_rst), .rst_next(rst_next),
    .rst_cause(rst_cause), .pc_load(pc_load), .pc_vec(pc_vec)
  );

  rcs_warmup #(.WARM_CYCLES(WARM_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_warm (
    .clk_hf(clk_hf), .warm_req(warm_req), .warm_done(warm_done)
  );

  rcs_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(clk_ring), .d(warm_done), .q(done_sync)
  );

  rcs_clk_select u_sel (
    .clk(clk_ring), .supply_ok(supply_ok), .core_rst(core_rst),
    .rst_next(rst_next), .sel_we(hf_sel_we), .sel_wdata(hf_sel_wdata),
    .done_sync(done_sync), .hf_sel_q(hf_sel_q), .warm_req(warm_req),
    .clk_sel(clk_sel)
  );
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int               VEC_W        = 16,
  parameter logic [VEC_W-1:0] RESET_VECTOR = 16'h8000
) (
  input logic             clk_ring,
  input logic             supply_ok,
  input logic             rst_pin_n,
  input logic             wdt_timeout,
  input logic             core_rst,
  input logic [1:0]       rst_cause,
  input logic             pc_load,
  input logic [VEC_W-1:0] pc_vec,
  input logic             hf_sel_q,
  input logic             clk_sel
);
  p_por_hold_r1: assert property (@(posedge clk_ring)
    !supply_ok |=> core_rst) else $error("R1 reset not held");

  p_por_cause_r4: assert property (@(posedge clk_ring)
    !supply_ok |=> (rst_cause == 2'b00)) else $error("R4 cause not power-on");

  p_sel_clear_r5: assert property (@(posedge clk_ring)
    !supply_ok |=> !hf_sel_q) else $error("R5 select bit survived power-on");

  p_ext_assert_r2: assert property (@(posedge clk_ring) disable iff (!supply_ok)
    (!rst_pin_n && !core_rst) |-> ##3 core_rst) else $error("R2 pin reset missed");

  p_wdt_assert_r7: assert property (@(posedge clk_ring) disable iff (!supply_ok)
    (wdt_timeout && !core_rst) |=> core_rst) else $error("R7 watchdog reset missed");

  p_exit_vector_r3: assert property (@(posedge clk_ring) disable iff (!supply_ok)
    $fell(core_rst) |-> (pc_load && pc_vec == RESET_VECTOR)) else $error("R3 exit load");

  p_load_pulse_r3: assert property (@(posedge clk_ring) disable iff (!supply_ok)
    pc_load |=> !pc_load) else $error("R3 load longer than one cycle");

  p_sel_gate_r6: assert property (@(posedge clk_ring) disable iff (!supply_ok)
    clk_sel |-> (!core_rst && hf_sel_q)) else $error("R6 clock select while gated");
endmodule

bind rst_clk_sequencer rcs_checker #(.VEC_W(VEC_W), .RESET_VECTOR(RESET_VECTOR)) u_rcs_checker (
  .clk_ring(clk_ring), .supply_ok(supply_ok), .rst_pin_n(rst_pin_n),
  .wdt_timeout(wdt_timeout), .core_rst(core_rst), .rst_cause(rst_cause),
  .pc_load(pc_load), .pc_vec(pc_vec), .hf_sel_q(hf_sel_q), .clk_sel(clk_sel)
);

// File: tb/rst_clk_sequencer_bench.sv
module rst_clk_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HF_PERIOD  = 4;
  localparam int POR_N      = 40;
  localparam int WARM_N     = 50;

  logic        clk_ring = 1'b0;
  logic        clk_hf   = 1'b0;
  logic        supply_ok = 1'b0;
  logic        rst_pin_n = 1'b1;
  logic        wdt_timeout = 1'b0;
  logic        hf_sel_we = 1'b0;
  logic        hf_sel_wdata = 1'b0;
  logic        core_rst;
  logic [1:0]  rst_cause;
  logic        pc_load;
  logic [15:0] pc_vec;
  logic        hf_sel_q;
  logic        clk_sel;

  int checks = 0;
  int failures = 0;
  int hf_edges = 0;

  always #(CLK_PERIOD/2) clk_ring = ~clk_ring;
  always #(HF_PERIOD/2) clk_hf = ~clk_hf;
  always @(posedge clk_hf) hf_edges <= hf_edges + 1;

  rst_clk_sequencer #(
    .POR_CYCLES(POR_N), .EXT_DELAY(4), .WDT_HOLD(4), .WARM_CYCLES(WARM_N)
  ) u_rst_clk_sequencer (
    .clk_ring(clk_ring), .clk_hf(clk_hf), .supply_ok(supply_ok),
    .rst_pin_n(rst_pin_n), .wdt_timeout(wdt_timeout), .hf_sel_we(hf_sel_we),
    .hf_sel_wdata(hf_sel_wdata), .core_rst(core_rst), .rst_cause(rst_cause),
    .pc_load(pc_load), .pc_vec(pc_vec), .hf_sel_q(hf_sel_q), .clk_sel(clk_sel)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_ring);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic pulse_wdt();
    wdt_timeout = 1'b1;
    cyc(1);
    wdt_timeout = 1'b0;
  endtask

  task automatic write_sel(input logic v);
    hf_sel_we = 1'b1;
    hf_sel_wdata = v;
    cyc(1);
    hf_sel_we = 1'b0;
  endtask

  // R6: count hf edges from t0 until clk_sel rises, judge the window
  task automatic expect_switch(input string tag, input int t0);
    int diff;
    for (int i = 0; i < 400; i++) begin
      if (clk_sel) break;
      cyc(1);
    end
    diff = hf_edges - t0;
    checks++;
    if (!clk_sel || diff < WARM_N || diff > WARM_N + 30) begin
      failures++;
      $display("FAIL %s actual=%0d sel=%0b expected=%0d..%0d sel=1",
               tag, diff, clk_sel, WARM_N, WARM_N + 30);
    end
  endtask

  task automatic t_reset_state();
    cyc(3);
    check("R1 core_rst during supply low", core_rst, 1);
    check("R4 cause power-on", rst_cause, 2'b00);
    check("R5 select cleared", hf_sel_q, 0);
    check("R6 clk_sel low", clk_sel, 0);
    check("R3 no load in reset", pc_load, 0);
  endtask

  task automatic t_por_release();
    supply_ok = 1'b1;
    cyc(POR_N);
    check("R1 still held at end of count", core_rst, 1);
    cyc(1);
    check("R1 released", core_rst, 0);
    check("R3 load strobe", pc_load, 1);
    check("R3 vector", pc_vec, 16'h8000);
    check("R4 cause power-on after exit", rst_cause, 2'b00);
    cyc(1);
    check("R3 strobe one cycle", pc_load, 0);
  endtask

  task automatic t_ext_reset();
    rst_pin_n = 1'b0;
    cyc(3);
    check("R2 pin asserts reset", core_rst, 1);
    check("R4 cause external", rst_cause, 2'b10);
    cyc(3);
    rst_pin_n = 1'b1;
    cyc(6);
    check("R2 held through delay", core_rst, 1);
    cyc(1);
    check("R2 released after delay", core_rst, 0);
    check("R3 load on ext exit", pc_load, 1);
  endtask

  task automatic t_wdt_reset();
    pulse_wdt();
    check("R7 watchdog asserts", core_rst, 1);
    check("R4 cause watchdog", rst_cause, 2'b01);
    cyc(3);
    check("R7 held for hold count", core_rst, 1);
    cyc(1);
    check("R7 released", core_rst, 0);
  endtask

  task automatic t_wdt_restart();
    pulse_wdt();
    cyc(1);
    pulse_wdt();
    cyc(3);
    check("R8 second pulse restarts hold", core_rst, 1);
    cyc(1);
    check("R8 release after restart", core_rst, 0);
  endtask

  task automatic t_same_edge();
    rst_pin_n = 1'b0;
    pulse_wdt();
    cyc(4);
    check("R4 pin outranks watchdog", rst_cause, 2'b10);
    check("R4 reset held", core_rst, 1);
    rst_pin_n = 1'b1;
    cyc(6);
    check("R2 ext timing after collision", core_rst, 1);
    cyc(1);
    check("R2 released after collision", core_rst, 0);
    check("R4 cause stays external", rst_cause, 2'b10);
  endtask

  task automatic t_switch();
    int t0;
    write_sel(1'b1);
    check("R5 select written", hf_sel_q, 1);
    check("R6 still on ring clock", clk_sel, 0);
    t0 = hf_edges;
    expect_switch("R6 warmup window", t0);
  endtask

  task automatic t_restart_warmup();
    int t0;
    pulse_wdt();
    check("R6 back to ring in reset", clk_sel, 0);
    check("R5 select survives watchdog", hf_sel_q, 1);
    cyc(4);
    check("R7 exit before warmup restart", core_rst, 0);
    cyc(10);
    pulse_wdt();
    check("R8 no switch after interrupted warmup", clk_sel, 0);
    cyc(4);
    t0 = hf_edges;
    expect_switch("R8 warmup counted from new exit", t0);
  endtask

  task automatic t_write_blocked();
    rst_pin_n = 1'b0;
    cyc(3);
    write_sel(1'b0);
    check("R5 write in reset ignored", hf_sel_q, 1);
    rst_pin_n = 1'b1;
    cyc(7);
    check("R5 select survives external", hf_sel_q, 1);
    check("R2 released", core_rst, 0);
    expect_switch("R6 switch after ext exit", hf_edges);
  endtask

  task automatic t_clear_sel();
    write_sel(1'b0);
    check("R9 select cleared", hf_sel_q, 0);
    check("R9 clk_sel drops same edge", clk_sel, 0);
    cyc(120);
    check("R6 no switch with bit clear", clk_sel, 0);
  endtask

  task automatic t_por_clears();
    write_sel(1'b1);
    supply_ok = 1'b0;
    cyc(2);
    check("R5 power-on clears select", hf_sel_q, 0);
    check("R4 cause power-on", rst_cause, 2'b00);
    supply_ok = 1'b1;
    rst_pin_n = 1'b0;
    pulse_wdt();
    cyc(4);
    rst_pin_n = 1'b1;
    cyc(POR_N - 5);
    check("R8 requests ignored in power-on count", core_rst, 1);
    cyc(1);
    check("R8 power-on timing kept", core_rst, 0);
    check("R8 cause still power-on", rst_cause, 2'b00);
    check("R6 ring after power-on", clk_sel, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk_ring);
    t_reset_state();
    t_por_release();
    cyc(3);
    t_ext_reset();
    cyc(3);
    t_wdt_reset();
    cyc(3);
    t_wdt_restart();
    cyc(3);
    t_same_edge();
    cyc(3);
    t_switch();
    cyc(3);
    t_restart_warmup();
    cyc(3);
    t_write_blocked();
    cyc(3);
    t_clear_sel();
    t_por_clears();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule